// File: doc/BRIEF.md
# DDR3 Bank Row-Timing Guard

This block sits beside a DDR3 command scheduler and tracks, for each of the eight banks, whether a row is open and how long ago that bank was last activated or precharged. From the decoded command stream it produces per-bank permission vectors for ACTIVATE, column access (READ/WRITE) and PRECHARGE, plus a permission for REFRESH. The scheduler issues a command only when the matching permission is high. Any command issued against a low permission is dropped and recorded in sticky error flags.

The activate-to-column, active-minimum, precharge-recovery and row-cycle limits are converted to clock counts. The conversion is ceil(limit / tCK), and the result depends on a speed-bin select. A separate interval timer raises a refresh request that stays up until it is acknowledged. The interval is halved while the high-temperature input is set.

Each bank runs a two-state machine: `BK_IDLE` and `BK_OPEN`. An accepted ACTIVATE takes `BK_IDLE` to `BK_OPEN`, and an accepted PRECHARGE takes `BK_OPEN` back to `BK_IDLE`. No other transition exists.

The refresh timer has two states, `RF_COUNT` and `RF_DUE`:
- `RF_COUNT` to `RF_DUE` happens when the interval elapses.
- Either state returns to `RF_COUNT` on an acknowledge, which also restarts the count.

The error recorder has two states, `ERR_CLEAN` and `ERR_HELD`. The first rejected command moves it from `ERR_CLEAN` to `ERR_HELD`, where it stays until reset.

Top module: `ddr3_bank_guard`

## Requirements
- R1: A command is taken when `cmd_valid` is 1. The `cmd_op` codes are 0 ACTIVATE, 1 READ, 2 WRITE, 3 PRECHARGE and 4 REFRESH; codes 5 to 7 change nothing. An accepted ACTIVATE sets `bank_open[cmd_bank]` after the sampling edge, and an accepted PRECHARGE clears it.
- R2: After an ACTIVATE to bank b is sampled at edge k, `rdwr_ok[b]` is 1 for a command sampled at edge k+tRCD or later, and 0 before that. It is 0 whenever bank b is closed.
- R3: `pre_ok[b]` is 1 only when bank b is open and at least tRAS edges have passed since its ACTIVATE.
- R4: `act_ok[b]` is 1 only when bank b is closed, at least tRP edges have passed since its last PRECHARGE, and at least tRC edges have passed since its last ACTIVATE.
- R5: The limits (tRCD/tRP/tRAS/tRC in clocks) are selected by `speed_bin` as follows:
  - 0: 6/6/15/21
  - 1: 7/7/20/27
  - 2: 8/8/20/28
  - 3: 8/8/24/32
  - 4: 9/9/24/33
  - Codes 5 to 7 select the same limits as code 4.
- R6: The following raise sticky `err_proto` and are dropped with no state change: READ, WRITE or PRECHARGE to a closed bank, ACTIVATE to an open bank, and REFRESH while any bank is open.
- R7: A command whose bank state is right but whose timer has not expired raises sticky `err_timing` and is dropped with no state change.
- R8: `err_bank` captures the bank of the first rejected command and holds it until reset. For a rejected REFRESH it is the lowest-numbered bank that blocks the refresh.
- R9: `ref_ok` is 1 only when every bank is closed and each bank's tRP has expired.
- R10: `ref_due` rises after the L-th clock edge following reset release or a sampled `ref_ack`, and stays 1 until `ref_ack`. L is ceil(TREFI_NS / tCK) clocks, which is 3120, 4160 and 5200 for bins 0, 1/2 and 3/4 at the default of 7800 ns.
- R11: While `temp_hot` is 1, L is halved (1560 for bin 0). The change takes effect at once on a count already in progress.
- R12: Out of reset, all of the following hold:
  - all banks are closed;
  - `act_ok` is all ones, and `rdwr_ok` and `pre_ok` are zero;
  - `ref_ok` is 1;
  - `ref_due`, `err_timing` and `err_proto` are 0.
- R13: A command to one bank changes no other bank's state or permissions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| speed_bin | input | 3 | Speed-bin select for timing limits |
| temp_hot | input | 1 | High case temperature, halves refresh interval |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Command code |
| cmd_bank | input | BANK_W | Target bank index |
| ref_ack | input | 1 | Acknowledge of the refresh request |
| act_ok | output | 2**BANK_W | ACTIVATE permitted per bank |
| rdwr_ok | output | 2**BANK_W | READ/WRITE permitted per bank |
| pre_ok | output | 2**BANK_W | PRECHARGE permitted per bank |
| ref_ok | output | 1 | REFRESH permitted |
| bank_open | output | 2**BANK_W | Row open per bank |
| ref_due | output | 1 | Refresh request, held until acknowledged |
| err_timing | output | 1 | Sticky timing violation |
| err_proto | output | 1 | Sticky protocol violation |
| err_bank | output | BANK_W | Bank of the first violation |

## Verification
A bank stuck in the wrong state shows on `bank_open` and on the permission vectors after the very next edge. A later command to that bank then also sets an error flag on the edge after it is sampled.

A miscounted timer is a different kind of fault. It makes a permission rise one or more edges early or late relative to the tRCD, tRAS or tRP count for the selected bin, and the bench measures that distance edge by edge for every bin.

A refresh counter that is off by one changes the cycle on which `ref_due` rises, which is thousands of edges after the acknowledge. A missed temperature switch delays the rise by up to a whole interval.

// File: rtl/ddr3_guard_pkg.sv
package ddr3_guard_pkg;

    localparam int LIM_W = 6;

    localparam logic [2:0] OP_ACT = 3'd0;
    localparam logic [2:0] OP_RD  = 3'd1;
    localparam logic [2:0] OP_WR  = 3'd2;
    localparam logic [2:0] OP_PRE = 3'd3;
    localparam logic [2:0] OP_REF = 3'd4;

    typedef struct packed {
        logic [LIM_W-1:0] rcd;
        logic [LIM_W-1:0] rp;
        logic [LIM_W-1:0] ras;
        logic [LIM_W-1:0] rc;
    } bank_lim_t;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int bin_tck_ps(input int bin);
        case (bin)
            0:       return 2500;
            1, 2:    return 1875;
            default: return 1500;
        endcase
    endfunction

    // activate-to-column and precharge recovery share one value per bin
    function automatic int bin_rcd_ps(input int bin);
        case (bin)
            0:       return 15000;
            1:       return 13125;
            2:       return 15000;
            3:       return 12000;
            default: return 13500;
        endcase
    endfunction

    function automatic int bin_ras_ps(input int bin);
        case (bin)
            0, 1, 2: return 37500;
            default: return 36000;
        endcase
    endfunction

    function automatic int bin_rc_ps(input int bin);
        case (bin)
            0:       return 52500;
            1:       return 50625;
            2:       return 52500;
            3:       return 48000;
            default: return 49500;
        endcase
    endfunction

endpackage

// File: rtl/ddr3_timing_lut.sv
module ddr3_timing_lut
    import ddr3_guard_pkg::*;
#(
    parameter int TREFI_NS = 7800,
    parameter int REF_W    = 14,
    parameter int SEL_W    = 3
) (
    input  logic [SEL_W-1:0] speed_bin,
    input  logic             temp_hot,
    output bank_lim_t        lim,
    output logic [REF_W-1:0] ref_limit
);
    localparam int N_BINS = 1 << SEL_W;

    bank_lim_t        lim_tab  [N_BINS];
    logic [REF_W-1:0] cold_tab [N_BINS];
    logic [REF_W-1:0] hot_tab  [N_BINS];

    for (genvar g = 0; g < N_BINS; g++) begin : g_bin
        assign lim_tab[g].rcd = LIM_W'(ceil_div(bin_rcd_ps(g), bin_tck_ps(g)));
        assign lim_tab[g].rp  = LIM_W'(ceil_div(bin_rcd_ps(g), bin_tck_ps(g)));
        assign lim_tab[g].ras = LIM_W'(ceil_div(bin_ras_ps(g), bin_tck_ps(g)));
        assign lim_tab[g].rc  = LIM_W'(ceil_div(bin_rc_ps(g),  bin_tck_ps(g)));
        assign cold_tab[g]    = REF_W'(ceil_div(TREFI_NS * 1000, bin_tck_ps(g)));
        assign hot_tab[g]     = REF_W'(ceil_div(TREFI_NS * 500,  bin_tck_ps(g)));
    end

    always_comb begin
        lim       = lim_tab[speed_bin];
        ref_limit = temp_hot ? hot_tab[speed_bin] : cold_tab[speed_bin];
    end
endmodule

// File: rtl/ddr3_bank_fsm.sv
module ddr3_bank_fsm
    import ddr3_guard_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  bank_lim_t lim,
    input  logic      act_go,
    input  logic      pre_go,
    output logic      is_open,
    output logic      act_ok,
    output logic      col_ok,
    output logic      pre_ok,
    output logic      ref_ready
);
    typedef enum logic {BK_IDLE, BK_OPEN} bank_state_e;

    bank_state_e      state_q, state_d;
    logic [LIM_W-1:0] rcd_q, ras_q, rc_q, rp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BK_IDLE: if (act_go) state_d = BK_OPEN;
            BK_OPEN: if (pre_go) state_d = BK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rcd_q <= '0;
            ras_q <= '0;
            rc_q  <= '0;
            rp_q  <= '0;
        end else begin
            if (act_go) begin
                rcd_q <= lim.rcd - LIM_W'(1);
                ras_q <= lim.ras - LIM_W'(1);
                rc_q  <= lim.rc  - LIM_W'(1);
            end else begin
                if (rcd_q != '0) rcd_q <= rcd_q - LIM_W'(1);
                if (ras_q != '0) ras_q <= ras_q - LIM_W'(1);
                if (rc_q  != '0) rc_q  <= rc_q  - LIM_W'(1);
            end
            if (pre_go)           rp_q <= lim.rp - LIM_W'(1);
            else if (rp_q != '0)  rp_q <= rp_q - LIM_W'(1);
        end
    end

    always_comb begin
        is_open   = (state_q == BK_OPEN);
        act_ok    = (state_q == BK_IDLE) && (rp_q == '0) && (rc_q == '0);
        col_ok    = (state_q == BK_OPEN) && (rcd_q == '0);
        pre_ok    = (state_q == BK_OPEN) && (ras_q == '0);
        ref_ready = (state_q == BK_IDLE) && (rp_q == '0);
    end
endmodule

// File: rtl/ddr3_refresh_timer.sv
module ddr3_refresh_timer #(
    parameter int REF_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REF_W-1:0] limit,
    input  logic             ack,
    output logic             due
);
    typedef enum logic {RF_COUNT, RF_DUE} ref_state_e;

    ref_state_e       state_q, state_d;
    logic [REF_W-1:0] cnt_q;
    logic             elapsed;

    assign elapsed = (cnt_q >= (limit - REF_W'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RF_COUNT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RF_COUNT: if (ack) state_d = RF_COUNT;
                      else if (elapsed) state_d = RF_DUE;
            RF_DUE:   if (ack) state_d = RF_COUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                          cnt_q <= '0;
        else if (ack)                                        cnt_q <= '0;
        else if (state_q == RF_COUNT && state_d == RF_COUNT) cnt_q <= cnt_q + REF_W'(1);
    end

    assign due = (state_q == RF_DUE);
endmodule

// File: rtl/ddr3_bank_guard.sv
module ddr3_bank_guard
    import ddr3_guard_pkg::*;
#(
    parameter int BANK_W   = 3,
    parameter int TREFI_NS = 7800,
    parameter int REF_W    = 14
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2:0]               speed_bin,
    input  logic                     temp_hot,
    input  logic                     cmd_valid,
    input  logic [2:0]               cmd_op,
    input  logic [BANK_W-1:0]        cmd_bank,
    input  logic                     ref_ack,
    output logic [(1<<BANK_W)-1:0]   act_ok,
    output logic [(1<<BANK_W)-1:0]   rdwr_ok,
    output logic [(1<<BANK_W)-1:0]   pre_ok,
    output logic                     ref_ok,
    output logic [(1<<BANK_W)-1:0]   bank_open,
    output logic                     ref_due,
    output logic                     err_timing,
    output logic                     err_proto,
    output logic [BANK_W-1:0]        err_bank
);
    localparam int NB = 1 << BANK_W;

    typedef enum logic {ERR_CLEAN, ERR_HELD} err_state_e;

    bank_lim_t        lim;
    logic [REF_W-1:0] ref_limit;
    logic [NB-1:0]    ref_ready;
    logic [NB-1:0]    act_go, pre_go;
    logic             is_act, is_col, is_pre, is_ref;
    logic             bad_proto, bad_timing;
    logic [BANK_W-1:0] bad_bank, ref_block;
    err_state_e       err_q, err_d;

    ddr3_timing_lut #(.TREFI_NS(TREFI_NS), .REF_W(REF_W), .SEL_W(3)) u_lut (
        .speed_bin (speed_bin),
        .temp_hot  (temp_hot),
        .lim       (lim),
        .ref_limit (ref_limit)
    );

    ddr3_refresh_timer #(.REF_W(REF_W)) u_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .limit (ref_limit),
        .ack   (ref_ack),
        .due   (ref_due)
    );

    always_comb begin
        is_act = cmd_valid && (cmd_op == OP_ACT);
        is_col = cmd_valid && ((cmd_op == OP_RD) || (cmd_op == OP_WR));
        is_pre = cmd_valid && (cmd_op == OP_PRE);
        is_ref = cmd_valid && (cmd_op == OP_REF);
    end

    for (genvar g = 0; g < NB; g++) begin : g_bank
        assign act_go[g] = is_act && (cmd_bank == BANK_W'(g)) && act_ok[g];
        assign pre_go[g] = is_pre && (cmd_bank == BANK_W'(g)) && pre_ok[g];

        ddr3_bank_fsm u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .lim       (lim),
            .act_go    (act_go[g]),
            .pre_go    (pre_go[g]),
            .is_open   (bank_open[g]),
            .act_ok    (act_ok[g]),
            .col_ok    (rdwr_ok[g]),
            .pre_ok    (pre_ok[g]),
            .ref_ready (ref_ready[g])
        );
    end

    assign ref_ok = &ref_ready;

    // lowest-numbered bank that keeps a refresh from issuing
    always_comb begin
        ref_block = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (!ref_ready[i]) ref_block = BANK_W'(i);
        end
    end

    always_comb begin
        bad_proto  = 1'b0;
        bad_timing = 1'b0;
        bad_bank   = cmd_bank;
        if (is_act) begin
            bad_proto  = bank_open[cmd_bank];
            bad_timing = !bank_open[cmd_bank] && !act_ok[cmd_bank];
        end else if (is_col) begin
            bad_proto  = !bank_open[cmd_bank];
            bad_timing = bank_open[cmd_bank] && !rdwr_ok[cmd_bank];
        end else if (is_pre) begin
            bad_proto  = !bank_open[cmd_bank];
            bad_timing = bank_open[cmd_bank] && !pre_ok[cmd_bank];
        end else if (is_ref) begin
            bad_proto  = |bank_open;
            bad_timing = !(|bank_open) && !ref_ok;
            bad_bank   = ref_block;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= ERR_CLEAN;
        else        err_q <= err_d;
    end

    always_comb begin
        err_d = err_q;
        unique case (err_q)
            ERR_CLEAN: if (bad_proto || bad_timing) err_d = ERR_HELD;
            ERR_HELD:  err_d = ERR_HELD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_timing <= 1'b0;
            err_proto  <= 1'b0;
            err_bank   <= '0;
        end else begin
            if (bad_timing) err_timing <= 1'b1;
            if (bad_proto)  err_proto  <= 1'b1;
            if (err_q == ERR_CLEAN && err_d == ERR_HELD) err_bank <= bad_bank;
        end
    end
endmodule

// File: rtl/ddr3_bank_guard_chk.sv
module ddr3_bank_guard_chk
    import ddr3_guard_pkg::*;
#(
    parameter int BANK_W = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cmd_valid,
    input logic [2:0]             cmd_op,
    input logic [BANK_W-1:0]      cmd_bank,
    input logic                   ref_ack,
    input logic [(1<<BANK_W)-1:0] act_ok,
    input logic [(1<<BANK_W)-1:0] rdwr_ok,
    input logic [(1<<BANK_W)-1:0] pre_ok,
    input logic [(1<<BANK_W)-1:0] bank_open,
    input logic                   ref_due,
    input logic                   err_timing,
    input logic                   err_proto,
    input logic [BANK_W-1:0]      err_bank
);
    assert_act_opens_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_ACT && act_ok[cmd_bank]) |=> bank_open[$past(cmd_bank)]);

    assert_rcd_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_ACT && act_ok[cmd_bank]) |=> !rdwr_ok[$past(cmd_bank)]);

    assert_rp_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_PRE && pre_ok[cmd_bank]) |=> !act_ok[$past(cmd_bank)]);

    assert_rejected_pre_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_PRE && !pre_ok[cmd_bank]) |=> $stable(bank_open));

    assert_timing_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_timing |=> err_timing);

    assert_proto_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_proto |=> err_proto);

    assert_bank_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_timing || err_proto) |=> $stable(err_bank));

    assert_due_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_due && !ref_ack) |=> ref_due);

    assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ack |=> !ref_due);
endmodule

bind ddr3_bank_guard ddr3_bank_guard_chk #(.BANK_W(BANK_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_bank   (cmd_bank),
    .ref_ack    (ref_ack),
    .act_ok     (act_ok),
    .rdwr_ok    (rdwr_ok),
    .pre_ok     (pre_ok),
    .bank_open  (bank_open),
    .ref_due    (ref_due),
    .err_timing (err_timing),
    .err_proto  (err_proto),
    .err_bank   (err_bank)
);

// File: tb/ddr3_bank_guard_bench.sv
`timescale 1ns/1ps
module ddr3_bank_guard_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] speed_bin = 3'd0;
    logic       temp_hot = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [2:0] cmd_bank = 3'd0;
    logic       ref_ack = 1'b0;
    logic [7:0] act_ok, rdwr_ok, pre_ok, bank_open;
    logic       ref_ok, ref_due, err_timing, err_proto;
    logic [2:0] err_bank;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    ddr3_bank_guard u_ddr3_bank_guard (
        .clk(clk), .rst_n(rst_n), .speed_bin(speed_bin), .temp_hot(temp_hot),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .ref_ack(ref_ack),
        .act_ok(act_ok), .rdwr_ok(rdwr_ok), .pre_ok(pre_ok), .ref_ok(ref_ok),
        .bank_open(bank_open), .ref_due(ref_due), .err_timing(err_timing),
        .err_proto(err_proto), .err_bank(err_bank)
    );

    // gap idle cycles, then op to bank; expected permission and bank_open after
    typedef struct packed {
        logic [7:0] gap;
        logic [2:0] op;
        logic [2:0] bank;
        logic       ok;
        logic       open;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{8'd0, 3'd0, 3'd0, 1'b1, 1'b1},
        '{8'd4, 3'd1, 3'd0, 1'b0, 1'b1},
        '{8'd0, 3'd1, 3'd0, 1'b1, 1'b1},
        '{8'd0, 3'd0, 3'd1, 1'b1, 1'b1},
        '{8'd0, 3'd2, 3'd1, 1'b0, 1'b1},
        '{8'd5, 3'd3, 3'd0, 1'b0, 1'b1},
        '{8'd0, 3'd3, 3'd0, 1'b1, 1'b0},
        '{8'd4, 3'd0, 3'd0, 1'b0, 1'b0},
        '{8'd0, 3'd0, 3'd0, 1'b1, 1'b1},
        '{8'd0, 3'd1, 3'd2, 1'b0, 1'b0},
        '{8'd0, 3'd3, 3'd1, 1'b1, 1'b0},
        '{8'd0, 3'd5, 3'd0, 1'b0, 1'b1},
        '{8'd0, 3'd4, 3'd0, 1'b0, 1'b1},
        '{8'd0, 3'd3, 3'd0, 1'b0, 1'b1}
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] bin, input logic hot);
        rst_n = 1'b0; cmd_valid = 1'b0; ref_ack = 1'b0;
        speed_bin = bin; temp_hot = hot;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // one command sampled at the next edge, returns after it
    task automatic issue(input logic [2:0] op, input logic [2:0] bank);
        cmd_valid = 1'b1; cmd_op = op; cmd_bank = bank;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic sweep_bin(input logic [2:0] bin, input int e_rcd, input int e_rp,
                             input int e_ras);
        int got_rcd = 0, got_ras = 0, got_rp = 0, got_ref = 0;
        do_reset(bin, 1'b0);
        issue(3'd0, 3'd3);
        for (int n = 1; n < 64; n++) begin
            if (rdwr_ok[3] && got_rcd == 0) got_rcd = n;
            if (pre_ok[3] && got_ras == 0) got_ras = n;
            if (got_rcd != 0 && got_ras != 0) break;
            @(negedge clk);
        end
        check($sformatf("R2 R5 tRCD bin%0d", bin), got_rcd, e_rcd);
        check($sformatf("R3 R5 tRAS bin%0d", bin), got_ras, e_ras);
        issue(3'd3, 3'd3);
        for (int n = 1; n < 64; n++) begin
            if (act_ok[3] && got_rp == 0) got_rp = n;
            if (ref_ok && got_ref == 0) got_ref = n;
            if (got_rp != 0 && got_ref != 0) break;
            @(negedge clk);
        end
        check($sformatf("R4 R5 tRP bin%0d", bin), got_rp, e_rp);
        check($sformatf("R9 ref_ok after tRP bin%0d", bin), got_ref, e_rp);
    endtask

    task automatic count_due(input string req, input int exp);
        int n = 0;
        while (!ref_due && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(req, n, exp);
    endtask

    task automatic ack_due();
        ref_ack = 1'b1;
        @(negedge clk);
        ref_ack = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R12 reset state
        do_reset(3'd0, 1'b0);
        check("R12 act_ok", act_ok, 8'hFF);
        check("R12 rdwr_ok", rdwr_ok, 0);
        check("R12 pre_ok", pre_ok, 0);
        check("R12 bank_open", bank_open, 0);
        check("R12 ref_ok", ref_ok, 1);
        check("R12 ref_due", ref_due, 0);
        check("R12 errors", {err_timing, err_proto}, 0);

        // vector walk at bin 0 (tRCD 6, tRP 6, tRAS 15, tRC 21)
        for (int i = 0; i < NV; i++) begin
            string tag;
            int    flag;
            repeat (int'(TBL[i].gap)) @(negedge clk);
            case (TBL[i].op)
                3'd0:       begin tag = "R4"; flag = act_ok[TBL[i].bank]; end
                3'd1, 3'd2: begin tag = "R2"; flag = rdwr_ok[TBL[i].bank]; end
                3'd3:       begin tag = "R3"; flag = pre_ok[TBL[i].bank]; end
                3'd4:       begin tag = "R9"; flag = ref_ok; end
                default:    begin tag = "R13"; flag = 0; end
            endcase
            check($sformatf("%s permission vec%0d", tag, i), flag, TBL[i].ok);
            issue(TBL[i].op, TBL[i].bank);
            check($sformatf("R1 R13 bank_open vec%0d", i), bank_open[TBL[i].bank], TBL[i].open);
        end
        check("R13 other banks untouched", bank_open[7:2], 0);

        // R6 R7 R8 error capture
        do_reset(3'd0, 1'b0);
        issue(3'd1, 3'd5);
        check("R6 err_proto", err_proto, 1);
        check("R6 no timing flag", err_timing, 0);
        check("R6 bank not opened", bank_open[5], 0);
        check("R8 err_bank first", err_bank, 5);
        issue(3'd0, 3'd2);
        issue(3'd1, 3'd2);
        check("R7 err_timing", err_timing, 1);
        check("R7 bank still open", bank_open[2], 1);
        check("R8 err_bank held", err_bank, 5);

        do_reset(3'd0, 1'b0);
        issue(3'd0, 3'd6);
        issue(3'd0, 3'd4);
        issue(3'd4, 3'd0);
        check("R6 refresh with open banks", err_proto, 1);
        check("R8 refresh lowest blocker", err_bank, 4);

        do_reset(3'd0, 1'b0);
        issue(3'd0, 3'd1);
        repeat (20) @(negedge clk);
        issue(3'd3, 3'd1);
        issue(3'd4, 3'd0);
        check("R7 refresh inside tRP", err_timing, 1);
        check("R7 refresh not proto", err_proto, 0);
        check("R8 refresh timing blocker", err_bank, 1);

        // R5 per-bin limits
        sweep_bin(3'd0, 6, 6, 15);
        sweep_bin(3'd1, 7, 7, 20);
        sweep_bin(3'd2, 8, 8, 20);
        sweep_bin(3'd3, 8, 8, 24);
        sweep_bin(3'd4, 9, 9, 24);
        sweep_bin(3'd7, 9, 9, 24);

        // R10 R11 refresh interval
        do_reset(3'd0, 1'b0);
        count_due("R10 first interval bin0", 3120);
        repeat (5) @(negedge clk);
        check("R10 due held", ref_due, 1);
        ack_due();
        check("R10 ack clears", ref_due, 0);
        count_due("R10 interval after ack", 3120);
        temp_hot = 1'b1;
        ack_due();
        count_due("R11 hot interval bin0", 1560);
        temp_hot = 1'b0;
        ack_due();
        repeat (2000) @(negedge clk);
        check("R11 not yet due", ref_due, 0);
        temp_hot = 1'b1;
        @(negedge clk);
        check("R11 hot takes effect at once", ref_due, 1);
        do_reset(3'd3, 1'b0);
        count_due("R10 first interval bin3", 5200);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule